// File: doc/BRIEF.md
# Indirect Data Address Generator

This block forms the data-memory addresses for a small 8-bit controller whose program and data memories are separate. It keeps eight 8-bit general registers. Any of the lowest four can act as the pointer for an indirect access. The lowest two can also step themselves: they can advance after use or retreat before use, which lets software keep a stack in data memory. One 8-bit data address space holds a 128-byte internal RAM at the bottom and a window of peripheral registers above it. Every location can be reached as a whole byte or as one bit.

Each cycle the decoder may present one access. An access carries an addressing mode, a pointer select, an immediate address, a bit flag with a bit index, and a write flag. The block answers in the same cycle with the read address, a region flag and a byte mask. When the pointer steps, it also returns the new pointer value and the register it goes to. Reads and writes use separate address buses. A write leaves on the write bus one cycle after its access. That cycle is the slot a read-modify-write needs, so a single-bit write changes only its selected bit. The ALU reaches the register file through one write port and one read port.

Top module: `idx_addr_gen`

## Requirements
- R1: After reset every general register reads 0 and `wr_en` is low.
- R2: A register write through `reg_we`/`reg_wsel`/`reg_wdata` is visible on `reg_rdata` at the next clock edge. When the same register also receives a pointer write-back in that cycle, the register-port write wins.
- R3: Mode 0 (direct) uses `acc_imm` as the address. Mode 1 (indirect) uses the register selected by `acc_ptr` (0 to 3 select registers 0 to 3).
- R4: Mode 2 (post-increment) on register 0 or 1 uses the pointer's current value as the address. In the same cycle it requests a write-back of that value plus one, and the register holds that value after the edge.
- R5: Mode 3 (pre-decrement) on register 0 or 1 uses the pointer's value minus one as the address and writes that value back to the pointer.
- R6: Modes 2 and 3 on register 2 or 3 behave as plain indirect access. They request no write-back and leave the register unchanged.
- R7: Pointer arithmetic wraps modulo 256: 0xFF plus one gives 0x00, and 0x00 minus one gives 0xFF.
- R8: `rd_sfr` and `wr_sfr` are high for addresses 0x80 to 0xFF (peripheral window) and low for 0x00 to 0x7F (RAM).
- R9: A bit access (`acc_bit`=1) produces the mask `1 << acc_bidx`. A byte access produces 0xFF.
- R10: `rd_en` is high for a valid read access and for a valid bit write. It is low for a byte write and when no access is valid.
- R11: One cycle after a valid write access, `wr_en` is high with `wr_addr`, `wr_mask` and `wr_sfr` equal to that access's address, mask and region. `wr_en` is low in every other cycle.
- R12: Without `acc_valid`, no write-back is requested and no pointer changes, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_mode | input | 2 | Mode: 0 direct, 1 indirect, 2 post-increment, 3 pre-decrement |
| acc_ptr | input | 2 | Pointer register select (registers 0 to 3) |
| acc_imm | input | 8 | Immediate address for direct mode |
| acc_bit | input | 1 | 1 = single-bit access, 0 = byte access |
| acc_bidx | input | 3 | Bit index for a bit access |
| acc_wr | input | 1 | 1 = access writes memory |
| reg_we | input | 1 | Register file write strobe |
| reg_wsel | input | 3 | Register file write select |
| reg_wdata | input | 8 | Register file write data |
| reg_rsel | input | 3 | Register file read select |
| reg_rdata | output | 8 | Register file read data |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | 8 | Read address |
| rd_sfr | output | 1 | Read address lies in the peripheral window |
| rd_mask | output | 8 | Byte mask of the current access |
| wr_en | output | 1 | Write strobe, one cycle after the access |
| wr_addr | output | 8 | Write address |
| wr_sfr | output | 1 | Write address lies in the peripheral window |
| wr_mask | output | 8 | Bits to change in the write |
| ptr_wb_en | output | 1 | Pointer write-back requested this cycle |
| ptr_wb_sel | output | 2 | Pointer receiving the write-back |
| ptr_wb_data | output | 8 | New pointer value |

## Verification
The assertions assume that the decoder holds the access fields steady between edges and that `acc_bidx` only matters when `acc_bit` is high. They assume no other agent writes the pointers. They also assume that a register-port write to a stepping pointer in the same cycle is a deliberate override. The stimulus changes inputs only on the falling edge and presents at most one access per cycle. It makes exactly one deliberate collision, on register 0, to cover the override rule. Pointer values are set up through the register port before each auto-modify sequence, so every wrap case starts from a known value.

// File: rtl/idx_pkg.sv
package idx_pkg;
   typedef enum logic [1:0] {
      AM_DIRECT   = 2'd0,
      AM_INDIRECT = 2'd1,
      AM_POSTINC  = 2'd2,
      AM_PREDEC   = 2'd3
   } amode_e;
endpackage

// File: rtl/idx_regfile.sv
module idx_regfile #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 8,
   parameter int NUM_PTR  = 4,
   localparam int SEL_W = $clog2(NUM_REGS),
   localparam int PTR_W = $clog2(NUM_PTR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alu_we,
   input  logic [SEL_W-1:0]  alu_sel,
   input  logic [DATA_W-1:0] alu_data,
   input  logic              wb_en,
   input  logic [PTR_W-1:0]  wb_sel,
   input  logic [DATA_W-1:0] wb_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic [PTR_W-1:0]  ptr_sel,
   output logic [DATA_W-1:0] ptr_data
);
   logic [DATA_W-1:0] q [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic alu_hit;
      logic wb_hit;
      assign alu_hit = alu_we && (int'(alu_sel) == i);
      if (i < NUM_PTR) begin : g_ptr
         assign wb_hit = wb_en && (int'(wb_sel) == i);
      end else begin : g_plain
         assign wb_hit = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q[i] <= '0;
         else if (alu_hit) q[i] <= alu_data;
         else if (wb_hit)  q[i] <= wb_data;
      end
   end

   assign rd_data  = q[rd_sel];
   assign ptr_data = q[ptr_sel];
endmodule

// File: rtl/idx_ptr_unit.sv
module idx_ptr_unit
   import idx_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_PTR  = 4,
   parameter int NUM_AUTO = 2,
   localparam int PTR_W = $clog2(NUM_PTR)
) (
   input  logic              valid,
   input  amode_e            mode,
   input  logic [PTR_W-1:0]  ptr_sel,
   input  logic [ADDR_W-1:0] ptr_val,
   input  logic [ADDR_W-1:0] imm,
   output logic [ADDR_W-1:0] addr,
   output logic              wb_en,
   output logic [ADDR_W-1:0] wb_data
);
   logic              auto_ok;
   logic [ADDR_W-1:0] inc_val;
   logic [ADDR_W-1:0] dec_val;

   if (NUM_AUTO > 0) begin : g_auto
      assign auto_ok = int'(ptr_sel) < NUM_AUTO;
   end else begin : g_no_auto
      assign auto_ok = 1'b0;
   end

   assign inc_val = ptr_val + ADDR_W'(1);
   assign dec_val = ptr_val - ADDR_W'(1);

   always_comb begin
      addr    = ptr_val;
      wb_en   = 1'b0;
      wb_data = ptr_val;
      unique case (mode)
         AM_DIRECT:   addr = imm;
         AM_INDIRECT: addr = ptr_val;
         AM_POSTINC: begin
            addr    = ptr_val;
            wb_en   = auto_ok;
            wb_data = inc_val;
         end
         AM_PREDEC: begin
            addr    = auto_ok ? dec_val : ptr_val;
            wb_en   = auto_ok;
            wb_data = dec_val;
         end
         default: addr = ptr_val;
      endcase
      wb_en = wb_en && valid;
   end
endmodule

// File: rtl/idx_mask_gen.sv
module idx_mask_gen #(
   parameter int DATA_W = 8,
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  logic              bit_mode,
   input  logic [BIT_W-1:0]  bidx,
   output logic [DATA_W-1:0] mask
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign mask[b] = !bit_mode || (int'(bidx) == b);
   end
endmodule

// File: rtl/idx_wr_stage.sv
module idx_wr_stage #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_en,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_sfr,
   input  logic [DATA_W-1:0] in_mask,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              wr_sfr,
   output logic [DATA_W-1:0] wr_mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_sfr  <= 1'b0;
         wr_mask <= '0;
      end else begin
         wr_en <= in_en;
         if (in_en) begin
            wr_addr <= in_addr;
            wr_sfr  <= in_sfr;
            wr_mask <= in_mask;
         end
      end
   end
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
   import idx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int NUM_REGS  = 8,
   parameter int NUM_PTR   = 4,
   parameter int NUM_AUTO  = 2,
   parameter int RAM_BYTES = 128,
   localparam int SEL_W = $clog2(NUM_REGS),
   localparam int PTR_W = $clog2(NUM_PTR),
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [1:0]        acc_mode,
   input  logic [PTR_W-1:0]  acc_ptr,
   input  logic [ADDR_W-1:0] acc_imm,
   input  logic              acc_bit,
   input  logic [BIT_W-1:0]  acc_bidx,
   input  logic              acc_wr,
   input  logic              reg_we,
   input  logic [SEL_W-1:0]  reg_wsel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [SEL_W-1:0]  reg_rsel,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_sfr,
   output logic [DATA_W-1:0] rd_mask,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              wr_sfr,
   output logic [DATA_W-1:0] wr_mask,
   output logic              ptr_wb_en,
   output logic [PTR_W-1:0]  ptr_wb_sel,
   output logic [ADDR_W-1:0] ptr_wb_data
);
   localparam logic [ADDR_W:0] RAM_LIM = (ADDR_W+1)'(RAM_BYTES);

   if (ADDR_W != DATA_W) begin : g_chk_width
      $error("pointer registers must be as wide as the address");
   end
   if (!(NUM_AUTO <= NUM_PTR && NUM_PTR < NUM_REGS)) begin : g_chk_counts
      $error("need NUM_AUTO <= NUM_PTR < NUM_REGS");
   end
   if (NUM_PTR < 2 || NUM_REGS < 2 || DATA_W < 2) begin : g_chk_min
      $error("select and index fields need at least one bit");
   end
   if (RAM_BYTES < 1 || RAM_BYTES > (1 << ADDR_W)) begin : g_chk_ram
      $error("RAM_BYTES must fit in the address space");
   end

   amode_e            mode;
   logic [DATA_W-1:0] ptr_val;

   assign mode = amode_e'(acc_mode);

   idx_regfile #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_PTR(NUM_PTR)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .alu_we(reg_we), .alu_sel(reg_wsel), .alu_data(reg_wdata),
      .wb_en(ptr_wb_en), .wb_sel(ptr_wb_sel), .wb_data(ptr_wb_data),
      .rd_sel(reg_rsel), .rd_data(reg_rdata),
      .ptr_sel(acc_ptr), .ptr_data(ptr_val)
   );

   idx_ptr_unit #(
      .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .NUM_AUTO(NUM_AUTO)
   ) u_ptr (
      .valid(acc_valid), .mode(mode), .ptr_sel(acc_ptr),
      .ptr_val(ptr_val), .imm(acc_imm),
      .addr(rd_addr), .wb_en(ptr_wb_en), .wb_data(ptr_wb_data)
   );

   assign ptr_wb_sel = acc_ptr;

   idx_mask_gen #(.DATA_W(DATA_W)) u_mask (
      .bit_mode(acc_bit), .bidx(acc_bidx), .mask(rd_mask)
   );

   assign rd_sfr = {1'b0, rd_addr} >= RAM_LIM;
   assign rd_en  = acc_valid && (!acc_wr || acc_bit);

   idx_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .in_en(acc_valid && acc_wr), .in_addr(rd_addr),
      .in_sfr(rd_sfr), .in_mask(rd_mask),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_sfr(wr_sfr), .wr_mask(wr_mask)
   );
endmodule

// File: rtl/idx_addr_gen_chk.sv
module idx_addr_gen_chk #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 8,
   parameter int NUM_PTR  = 4,
   parameter int NUM_AUTO = 2,
   localparam int PTR_W = $clog2(NUM_PTR)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [1:0]        acc_mode,
   input logic [PTR_W-1:0]  acc_ptr,
   input logic              acc_bit,
   input logic              acc_wr,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_mask,
   input logic [DATA_W-1:0] wr_mask,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              ptr_wb_en,
   input logic [ADDR_W-1:0] ptr_wb_data
);
   a_r11_wr_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_wr) |=> wr_en);
   a_r11_no_stray_wr: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_wr) |=> !wr_en);
   a_r11_wr_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_wr) |=> (wr_addr == $past(rd_addr) && wr_mask == $past(rd_mask)));
   a_r10_byte_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_wr && !acc_bit) |-> !rd_en);
   a_r9_bit_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      acc_bit |-> ($countones(rd_mask) == 1));
   a_r4_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_mode == 2'd2 && int'(acc_ptr) < NUM_AUTO)
         |-> (ptr_wb_en && ptr_wb_data == rd_addr + ADDR_W'(1)));
   a_r5_predec_step: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_mode == 2'd3 && int'(acc_ptr) < NUM_AUTO)
         |-> (ptr_wb_en && ptr_wb_data == rd_addr));
   a_r6_no_step_high_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(acc_ptr) >= NUM_AUTO) |-> !ptr_wb_en);
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!ptr_wb_en && !rd_en));
endmodule

bind idx_addr_gen idx_addr_gen_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .NUM_AUTO(NUM_AUTO)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_mode(acc_mode),
   .acc_ptr(acc_ptr), .acc_bit(acc_bit), .acc_wr(acc_wr),
   .rd_en(rd_en), .rd_addr(rd_addr), .rd_mask(rd_mask), .wr_mask(wr_mask),
   .wr_en(wr_en), .wr_addr(wr_addr),
   .ptr_wb_en(ptr_wb_en), .ptr_wb_data(ptr_wb_data)
);

// File: tb/sim_idx_addr_gen.sv
module sim_idx_addr_gen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [1:0] acc_mode = '0;
   logic [1:0] acc_ptr = '0;
   logic [7:0] acc_imm = '0;
   logic       acc_bit = 1'b0;
   logic [2:0] acc_bidx = '0;
   logic       acc_wr = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_wsel = '0;
   logic [7:0] reg_wdata = '0;
   logic [2:0] reg_rsel = '0;
   logic [7:0] reg_rdata;
   logic       rd_en, rd_sfr, wr_en, wr_sfr, ptr_wb_en;
   logic [7:0] rd_addr, rd_mask, wr_addr, wr_mask, ptr_wb_data;
   logic [1:0] ptr_wb_sel;

   int checks = 0;
   int errors = 0;
   logic [7:0] mdl [8];

   typedef struct {
      logic [7:0] addr;
      logic [7:0] mask;
      logic       sfr;
   } exp_t;
   exp_t wq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   idx_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_mode(acc_mode),
      .acc_ptr(acc_ptr), .acc_imm(acc_imm), .acc_bit(acc_bit),
      .acc_bidx(acc_bidx), .acc_wr(acc_wr), .reg_we(reg_we),
      .reg_wsel(reg_wsel), .reg_wdata(reg_wdata), .reg_rsel(reg_rsel),
      .reg_rdata(reg_rdata), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_sfr(rd_sfr), .rd_mask(rd_mask), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_sfr(wr_sfr), .wr_mask(wr_mask), .ptr_wb_en(ptr_wb_en),
      .ptr_wb_sel(ptr_wb_sel), .ptr_wb_data(ptr_wb_data)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: pops expected write-side items (R11, R8, R9)
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         if (wq.size() == 0) begin
            check(1'b0, "R11 unexpected wr_en", 16'(wr_en), 16'h0);
         end else begin
            exp_t e;
            e = wq.pop_front();
            check(wr_addr == e.addr, "R11 wr_addr", 16'(wr_addr), 16'(e.addr));
            check(wr_mask == e.mask, "R9 wr_mask", 16'(wr_mask), 16'(e.mask));
            check(wr_sfr == e.sfr, "R8 wr_sfr", 16'(wr_sfr), 16'(e.sfr));
         end
      end
   end

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      check(1'b0, "watchdog", 16'h0, 16'h1);
      finish_sim();
   end

   task automatic reg_write(input int sel, input logic [7:0] val);
      @(negedge clk);
      acc_valid = 1'b0;
      reg_we = 1'b1; reg_wsel = 3'(sel); reg_wdata = val;
      @(posedge clk);
      mdl[sel] = val;
   endtask

   task automatic idle(input string req);
      @(negedge clk);
      acc_valid = 1'b0; reg_we = 1'b0; acc_mode = 2'd2; acc_ptr = 2'd0;
      #1;
      check(rd_en == 1'b0, req, 16'(rd_en), 16'h0);
      check(ptr_wb_en == 1'b0, req, 16'(ptr_wb_en), 16'h0);
      @(posedge clk);
   endtask

   task automatic chk_reg(input int sel, input string req);
      reg_rsel = 3'(sel);
      #1;
      check(reg_rdata == mdl[sel], req, 16'(reg_rdata), 16'(mdl[sel]));
   endtask

   task automatic access(input int mode, input int ptr, input logic [7:0] imm,
                         input bit bitm, input int bidx, input bit wr,
                         input string req);
      logic [7:0] pv, ea, em;
      bit auto_m;
      @(negedge clk);
      reg_we = 1'b0;
      acc_valid = 1'b1; acc_mode = 2'(mode); acc_ptr = 2'(ptr);
      acc_imm = imm; acc_bit = bitm; acc_bidx = 3'(bidx); acc_wr = wr;
      #1;
      pv = mdl[ptr];
      auto_m = (mode >= 2) && (ptr < 2);
      case (mode)
         0: ea = imm;
         3: ea = auto_m ? pv - 8'd1 : pv;
         default: ea = pv;
      endcase
      em = bitm ? (8'd1 << bidx) : 8'hFF;
      check(rd_addr == ea, req, 16'(rd_addr), 16'(ea));
      check(rd_mask == em, {req, " R9 mask"}, 16'(rd_mask), 16'(em));
      check(rd_sfr == (ea >= 8'h80), {req, " R8 region"}, 16'(rd_sfr), 16'(ea >= 8'h80));
      check(rd_en == (!wr || bitm), {req, " R10 rd_en"}, 16'(rd_en), 16'(!wr || bitm));
      check(ptr_wb_en == auto_m, {req, " R6 wb_en"}, 16'(ptr_wb_en), 16'(auto_m));
      if (wr) wq.push_back('{addr: ea, mask: em, sfr: (ea >= 8'h80)});
      @(posedge clk);
      if (auto_m) mdl[ptr] = (mode == 2) ? pv + 8'd1 : pv - 8'd1;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int i = 0; i < 8; i++) chk_reg(i, "R1 reg reset");
      check(wr_en == 1'b0, "R1 wr_en", 16'(wr_en), 16'h0);

      // R2: register port
      for (int i = 0; i < 8; i++) reg_write(i, 8'(8'h11 * (i + 1)));
      for (int i = 0; i < 8; i++) chk_reg(i, "R2 reg write");

      // R3: direct and indirect
      access(0, 0, 8'h25, 0, 0, 0, "R3 direct");
      access(1, 2, 8'h00, 0, 0, 0, "R3 indirect r2");
      access(1, 3, 8'h00, 0, 0, 1, "R3 indirect r3 write");

      // R4: post-increment on R0
      reg_write(0, 8'h10);
      for (int k = 0; k < 3; k++) access(2, 0, 8'h00, 0, 0, 0, "R4 postinc");
      chk_reg(0, "R4 pointer after postinc");

      // R5: pre-decrement on R1
      reg_write(1, 8'h40);
      access(3, 1, 8'h00, 0, 0, 1, "R5 predec byte write");
      access(3, 1, 8'h00, 1, 5, 0, "R5 predec bit read");
      chk_reg(1, "R5 pointer after predec");

      // R6: auto-modify modes on R2/R3 act as indirect
      access(2, 2, 8'h00, 0, 0, 0, "R6 postinc r2");
      access(3, 3, 8'h00, 0, 0, 0, "R6 predec r3");
      chk_reg(2, "R6 r2 unchanged");
      chk_reg(3, "R6 r3 unchanged");

      // R7: wrap
      reg_write(0, 8'hFF);
      access(2, 0, 8'h00, 0, 0, 1, "R7 postinc wrap");
      chk_reg(0, "R7 r0 wraps to 00");
      reg_write(1, 8'h00);
      access(3, 1, 8'h00, 0, 0, 1, "R7 predec wrap");
      chk_reg(1, "R7 r1 wraps to FF");

      // R8: region boundary
      access(0, 0, 8'h7F, 0, 0, 1, "R8 last RAM");
      access(0, 0, 8'h80, 0, 0, 1, "R8 first SFR");

      // R9/R10: bit writes at every index, then byte write
      for (int b = 0; b < 8; b++) access(0, 0, 8'h90, 1, b, 1, "R9 bit write");
      access(0, 0, 8'h33, 0, 0, 1, "R10 byte write");
      idle("R10 idle no read");

      // R12: no access -> no pointer change
      reg_write(0, 8'h55);
      idle("R12 idle no wb");
      chk_reg(0, "R12 r0 unchanged");

      // R2: collision, register port wins over write-back
      @(negedge clk);
      acc_valid = 1'b1; acc_mode = 2'd2; acc_ptr = 2'd0; acc_wr = 1'b0; acc_bit = 1'b0;
      reg_we = 1'b1; reg_wsel = 3'd0; reg_wdata = 8'hA7;
      @(posedge clk);
      mdl[0] = 8'hA7;
      chk_reg(0, "R2 port beats write-back");

      idle("R12 tail");
      idle("R12 tail");
      check(wq.size() == 0, "R11 pending writes", 16'(wq.size()), 16'h0);
      finish_sim();
   end
endmodule